// File: doc/BRIEF.md
# Timer Interrupt Steering and Level Status

This block sits between a bank of timers and the interrupt fabric. Each timer raises a one-cycle fire strobe when it expires; the block looks at that timer's stored configuration and turns the strobe into one of three things: a message-signalled interrupt (an 8-bit vector and an 8-bit destination), a one-cycle pulse on one of 32 interrupt-controller pins, or a held level on such a pin. Level interrupts are tracked in a per-timer status vector that software clears by writing ones.

A global legacy-route input moves timers 0 and 1 onto two fixed pins as edge interrupts, ahead of any message or route setting. Configuration and message words are written through one 64-bit write port with a target select. A route outside the timer's allowed-pin mask is stored as zero (not connected). A held level whose timer is no longer set up to drive it on the same pin is dropped without software help. When several timers want a message in the same cycle, messages leave one per cycle, lowest timer first.

Top module: `irq_steer_top`

## Requirements
- R1: A fire on an enabled timer whose config bit 1 is 0 and whose route (config bits 13:9) is non-zero produces a one-cycle pulse on `pin_pulse_o` at that pin in the cycle after the fire edge, and sets no status bit.
- R2: A fire on an enabled timer whose config bit 1 is 1 and whose route is non-zero sets that timer's `status_o` bit, strobes `pin_assert_o` at the route pin for one cycle, and holds `pin_level_o` at that pin until the status bit is cleared.
- R3: A fire is ignored when the timer's enable bit (config bit 2) is 0, or when its status bit is already set.
- R4: Route 0 means not connected and gives no pin event; a written route whose bit is clear in the timer's allowed-pin mask parameter (default: pins 8 to 23) is stored as 0.
- R5: When the timer is message-capable (parameter) and config bit 14 is 1, a fire raises `msi_valid_o` with the vector taken from bits 7:0 and the destination from bits 51:44 of that timer's message word; destination 0xFF raises `msi_bcast_o`; no pin event occurs.
- R6: While `legacy_i` is 1, timer 0 pulses pin 2 and timer 1 pulses pin 8 as edge interrupts whatever their type, message enable or route; other timers are unaffected.
- R7: A status write clears every set status bit whose written bit is 1, strobes `pin_deassert_o` at the recorded pin and drops the level; written 0 bits have no effect.
- R8: A set status bit is cleared, with a deassert strobe at its recorded pin, one cycle after the configuration stops steering that timer as an enabled level interrupt to that same pin (disable, edge type, message, other route or legacy routing).
- R9: Message requests from several timers are issued one per cycle in ascending timer order; a repeated fire while a request is still waiting merges into it.
- R10: Pin events from several timers in the same cycle are combined per pin by OR.
- R11: After reset all status bits, pin outputs and message outputs are 0 and every stored configuration is zero, so fires have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fire_i | input | NT | Per-timer fire strobes |
| legacy_i | input | 1 | Global legacy-route enable |
| wr_en_i | input | 1 | Write strobe for configuration or message words |
| wr_tgt_i | input | 1 | Write target: 0 configuration word, 1 message word |
| wr_idx_i | input | IW | Timer index of the write |
| wr_data_i | input | 64 | Written word |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | NT | Status bits to clear (1 clears) |
| pin_pulse_o | output | 32 | One-cycle edge pulses per pin |
| pin_assert_o | output | 32 | One-cycle level-assert strobes per pin |
| pin_deassert_o | output | 32 | One-cycle level-deassert strobes per pin |
| pin_level_o | output | 32 | Held level per pin |
| status_o | output | NT | Level status bits |
| msi_valid_o | output | 1 | Message request present |
| msi_vector_o | output | 8 | Message vector |
| msi_dest_o | output | 8 | Message destination |
| msi_bcast_o | output | 1 | Destination is broadcast |
| msi_src_o | output | IW | Timer issuing the message |

## Verification
A wrong status bit shows at the ports within one cycle: `pin_level_o` loses or gains a pin, a repeated fire is swallowed or not, and a stale level fails to produce its deassert strobe one cycle after the configuration write. A wrong route decode or a lost mask check shows as a pulse on the wrong pin, or a pulse where none is due, in the cycle after the fire edge. A broken message queue shows as a wrong `msi_src_o` order or an extra issued cycle when two timers fire together and one fires again.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

    // config word field positions
    localparam int BIT_LVL  = 1;
    localparam int BIT_EN   = 2;
    localparam int ROUTE_LO = 9;
    localparam int ROUTE_W  = 5;
    localparam int BIT_MSI  = 14;
    localparam int NPIN     = 1 << ROUTE_W;

    // message word field positions
    localparam int VEC_LO = 0;
    localparam int VEC_W  = 8;
    localparam int DST_LO = 44;
    localparam int DST_W  = 8;
    localparam logic [DST_W-1:0] DST_ALL = '1;

    typedef enum logic [1:0] {
        DLV_NONE  = 2'd0,
        DLV_EDGE  = 2'd1,
        DLV_LEVEL = 2'd2,
        DLV_MSI   = 2'd3
    } dlv_e;

    typedef enum logic {
        WT_CFG = 1'b0,
        WT_MSI = 1'b1
    } wtgt_e;

    typedef struct packed {
        logic               msi_en;
        logic [ROUTE_W-1:0] route;
        logic               en;
        logic               lvl;
    } tcfg_t;

    typedef struct packed {
        logic [DST_W-1:0] dst;
        logic [VEC_W-1:0] vec;
    } msiw_t;

    typedef struct packed {
        dlv_e               kind;
        logic [ROUTE_W-1:0] pin;
    } steer_t;

    // one-hot pin mask
    function automatic logic [NPIN-1:0] pin_bit(input logic [ROUTE_W-1:0] p);
        return NPIN'(1) << p;
    endfunction

    // pull the writable fields out of a config word, rejecting routes outside the mask
    function automatic tcfg_t take_cfg(input logic [63:0] w, input logic [NPIN-1:0] allowed);
        tcfg_t c;
        c.lvl    = w[BIT_LVL];
        c.en     = w[BIT_EN];
        c.msi_en = w[BIT_MSI];
        c.route  = w[ROUTE_LO +: ROUTE_W];
        if (c.route != '0 && !allowed[c.route])
            c.route = '0;
        return c;
    endfunction

    function automatic msiw_t take_msi(input logic [63:0] w);
        msiw_t m;
        m.vec = w[VEC_LO +: VEC_W];
        m.dst = w[DST_LO +: DST_W];
        return m;
    endfunction

    // delivery decision; legacy routing first, then message, then pin route
    function automatic steer_t decide(input tcfg_t c, input logic msi_cap,
                                      input logic legacy, input logic is_leg,
                                      input logic [ROUTE_W-1:0] leg_pin);
        steer_t s;
        s.kind = DLV_NONE;
        s.pin  = '0;
        if (legacy && is_leg) begin
            s.kind = DLV_EDGE;
            s.pin  = leg_pin;
        end else if (msi_cap && c.msi_en) begin
            s.kind = DLV_MSI;
        end else if (c.route != '0) begin
            s.pin  = c.route;
            s.kind = c.lvl ? DLV_LEVEL : DLV_EDGE;
        end
        return s;
    endfunction

endpackage

// File: rtl/tmr_cfg_bank.sv
module tmr_cfg_bank
    import irq_steer_pkg::*;
#(
    parameter int                    NT      = 8,
    parameter int                    IW      = 3,
    parameter logic [NT*NPIN-1:0]    ALLOWED = {NT{32'h00FF_FF00}}
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en_i,
    input  logic                 wr_tgt_i,
    input  logic [IW-1:0]        wr_idx_i,
    input  logic [63:0]          wr_data_i,
    output tcfg_t [NT-1:0]       cfg_o,
    output msiw_t [NT-1:0]       msi_o
);

    wtgt_e tgt;
    assign tgt = wtgt_e'(wr_tgt_i);

    for (genvar i = 0; i < NT; i++) begin : g_tmr
        localparam logic [NPIN-1:0] MASK = ALLOWED[i*NPIN +: NPIN];

        logic hit;
        assign hit = wr_en_i && (wr_idx_i == IW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_o[i] <= '0;
                msi_o[i] <= '0;
            end else if (hit) begin
                if (tgt == WT_CFG)
                    cfg_o[i] <= take_cfg(wr_data_i, MASK);
                else
                    msi_o[i] <= take_msi(wr_data_i);
            end
        end
    end

endmodule

// File: rtl/tmr_route_dec.sv
module tmr_route_dec
    import irq_steer_pkg::*;
#(
    parameter int            NT       = 8,
    parameter logic [NT-1:0] MSI_CAP  = '1,
    parameter int            LEG_PIN0 = 2,
    parameter int            LEG_PIN1 = 8
) (
    input  tcfg_t  [NT-1:0] cfg_i,
    input  logic            legacy_i,
    output steer_t [NT-1:0] steer_o
);

    for (genvar i = 0; i < NT; i++) begin : g_dec
        localparam logic               IS_LEG = (i < 2);
        localparam logic [ROUTE_W-1:0] LPIN   =
            (i == 0) ? ROUTE_W'(LEG_PIN0) : ROUTE_W'(LEG_PIN1);

        assign steer_o[i] = decide(cfg_i[i], MSI_CAP[i], legacy_i, IS_LEG, LPIN);
    end

endmodule

// File: rtl/irq_pin_ctl.sv
module irq_pin_ctl
    import irq_steer_pkg::*;
#(
    parameter int NT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NT-1:0]     fire_i,
    input  tcfg_t  [NT-1:0]   cfg_i,
    input  steer_t [NT-1:0]   steer_i,
    input  logic              sts_wr_i,
    input  logic [NT-1:0]     sts_wdata_i,
    output logic [NT-1:0]     status_o,
    output logic [NT-1:0]     msi_req_o,
    output logic [NPIN-1:0]   pulse_o,
    output logic [NPIN-1:0]   assert_o,
    output logic [NPIN-1:0]   deassert_o,
    output logic [NPIN-1:0]   level_o
);

    logic [NT-1:0]              sts_q;
    logic [NT-1:0][ROUTE_W-1:0] lpin_q;

    logic [NT-1:0]   accept;
    logic [NT-1:0]   set_lvl;
    logic [NT-1:0]   stale;
    logic [NT-1:0]   clr;
    logic [NPIN-1:0] pulse_d;
    logic [NPIN-1:0] assert_d;
    logic [NPIN-1:0] deassert_d;
    logic [NPIN-1:0] level_d;

    always_comb begin
        pulse_d    = '0;
        assert_d   = '0;
        deassert_d = '0;
        level_d    = '0;
        for (int i = 0; i < NT; i++) begin
            // a fire counts only if enabled and no level is outstanding
            accept[i]    = fire_i[i] && cfg_i[i].en && !sts_q[i];
            set_lvl[i]   = accept[i] && (steer_i[i].kind == DLV_LEVEL);
            msi_req_o[i] = accept[i] && (steer_i[i].kind == DLV_MSI);

            // outstanding level no longer matches the steering
            stale[i] = sts_q[i] &&
                       (!cfg_i[i].en ||
                        steer_i[i].kind != DLV_LEVEL ||
                        steer_i[i].pin  != lpin_q[i]);
            clr[i]   = sts_q[i] && ((sts_wr_i && sts_wdata_i[i]) || stale[i]);

            if (accept[i] && steer_i[i].kind == DLV_EDGE)
                pulse_d |= pin_bit(steer_i[i].pin);
            if (set_lvl[i])
                assert_d |= pin_bit(steer_i[i].pin);
            if (clr[i])
                deassert_d |= pin_bit(lpin_q[i]);
            if (sts_q[i])
                level_d |= pin_bit(lpin_q[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q      <= '0;
            lpin_q     <= '0;
            pulse_o    <= '0;
            assert_o   <= '0;
            deassert_o <= '0;
        end else begin
            sts_q      <= (sts_q & ~clr) | set_lvl;
            pulse_o    <= pulse_d;
            assert_o   <= assert_d;
            deassert_o <= deassert_d;
            for (int i = 0; i < NT; i++) begin
                if (set_lvl[i])
                    lpin_q[i] <= steer_i[i].pin;
            end
        end
    end

    assign status_o = sts_q;
    assign level_o  = level_d;

endmodule

// File: rtl/msi_issue.sv
module msi_issue
    import irq_steer_pkg::*;
#(
    parameter int NT = 8,
    parameter int IW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NT-1:0]     req_i,
    input  msiw_t [NT-1:0]    msi_i,
    output logic              valid_o,
    output logic [VEC_W-1:0]  vector_o,
    output logic [DST_W-1:0]  dest_o,
    output logic              bcast_o,
    output logic [IW-1:0]     src_o
);

    logic [NT-1:0] pend_q;
    logic [NT-1:0] grant;
    logic [IW-1:0] src;

    // lowest pending timer wins
    always_comb begin
        grant = '0;
        src   = '0;
        for (int i = NT - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                src      = IW'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~grant) | req_i;
    end

    assign valid_o  = |pend_q;
    assign src_o    = src;
    assign vector_o = valid_o ? msi_i[src].vec : '0;
    assign dest_o   = valid_o ? msi_i[src].dst : '0;
    assign bcast_o  = valid_o && (msi_i[src].dst == DST_ALL);

endmodule

// File: rtl/irq_steer_top.sv
module irq_steer_top
    import irq_steer_pkg::*;
#(
    parameter int                 NT       = 8,
    parameter logic [NT*32-1:0]   ALLOWED  = {NT{32'h00FF_FF00}},
    parameter logic [NT-1:0]      MSI_CAP  = '1,
    parameter int                 LEG_PIN0 = 2,
    parameter int                 LEG_PIN1 = 8,
    localparam int                IW       = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NT-1:0]     fire_i,
    input  logic              legacy_i,
    input  logic              wr_en_i,
    input  logic              wr_tgt_i,
    input  logic [IW-1:0]     wr_idx_i,
    input  logic [63:0]       wr_data_i,
    input  logic              sts_wr_i,
    input  logic [NT-1:0]     sts_wdata_i,
    output logic [31:0]       pin_pulse_o,
    output logic [31:0]       pin_assert_o,
    output logic [31:0]       pin_deassert_o,
    output logic [31:0]       pin_level_o,
    output logic [NT-1:0]     status_o,
    output logic              msi_valid_o,
    output logic [7:0]        msi_vector_o,
    output logic [7:0]        msi_dest_o,
    output logic              msi_bcast_o,
    output logic [IW-1:0]     msi_src_o
);

    tcfg_t  [NT-1:0] cfg;
    msiw_t  [NT-1:0] msi;
    steer_t [NT-1:0] steer;
    logic   [NT-1:0] msi_req;

    tmr_cfg_bank #(
        .NT      (NT),
        .IW      (IW),
        .ALLOWED (ALLOWED)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_tgt_i  (wr_tgt_i),
        .wr_idx_i  (wr_idx_i),
        .wr_data_i (wr_data_i),
        .cfg_o     (cfg),
        .msi_o     (msi)
    );

    tmr_route_dec #(
        .NT       (NT),
        .MSI_CAP  (MSI_CAP),
        .LEG_PIN0 (LEG_PIN0),
        .LEG_PIN1 (LEG_PIN1)
    ) u_dec (
        .cfg_i    (cfg),
        .legacy_i (legacy_i),
        .steer_o  (steer)
    );

    irq_pin_ctl #(
        .NT (NT)
    ) u_pin (
        .clk         (clk),
        .rst         (rst),
        .fire_i      (fire_i),
        .cfg_i       (cfg),
        .steer_i     (steer),
        .sts_wr_i    (sts_wr_i),
        .sts_wdata_i (sts_wdata_i),
        .status_o    (status_o),
        .msi_req_o   (msi_req),
        .pulse_o     (pin_pulse_o),
        .assert_o    (pin_assert_o),
        .deassert_o  (pin_deassert_o),
        .level_o     (pin_level_o)
    );

    msi_issue #(
        .NT (NT),
        .IW (IW)
    ) u_msi (
        .clk      (clk),
        .rst      (rst),
        .req_i    (msi_req),
        .msi_i    (msi),
        .valid_o  (msi_valid_o),
        .vector_o (msi_vector_o),
        .dest_o   (msi_dest_o),
        .bcast_o  (msi_bcast_o),
        .src_o    (msi_src_o)
    );

endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk #(
    parameter int NT = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [NT-1:0] fire_i,
    input logic          sts_wr_i,
    input logic [NT-1:0] sts_wdata_i,
    input logic [31:0]   pin_pulse_o,
    input logic [31:0]   pin_deassert_o,
    input logic [31:0]   pin_level_o,
    input logic [NT-1:0] status_o,
    input logic          msi_valid_o
);

    // R7
    sts_clear_chk: assert property (@(posedge clk) disable iff (rst)
        sts_wr_i |=> ((status_o & $past(status_o) & $past(sts_wdata_i)) == '0));

    // R2
    lvl_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        (|status_o) == (|pin_level_o));

    // R2
    sts_origin_chk: assert property (@(posedge clk) disable iff (rst)
        ((status_o & ~$past(status_o) & ~$past(fire_i)) == '0));

    // R8
    deassert_match_chk: assert property (@(posedge clk) disable iff (rst)
        (|(~status_o & $past(status_o))) == (|pin_deassert_o));

    // R1
    pulse_origin_chk: assert property (@(posedge clk) disable iff (rst)
        (|pin_pulse_o) |-> $past(|fire_i));

    // R5
    msi_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(msi_valid_o) |-> $past(|fire_i));

endmodule

bind irq_steer_top irq_steer_chk #(.NT(NT)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .fire_i         (fire_i),
    .sts_wr_i       (sts_wr_i),
    .sts_wdata_i    (sts_wdata_i),
    .pin_pulse_o    (pin_pulse_o),
    .pin_deassert_o (pin_deassert_o),
    .pin_level_o    (pin_level_o),
    .status_o       (status_o),
    .msi_valid_o    (msi_valid_o)
);

// File: tb/tb_irq_steer_top.sv
module tb_irq_steer_top;

    localparam int CLK_PERIOD = 10;
    localparam int NT = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NT-1:0] fire_i = '0;
    logic          legacy_i = 1'b0;
    logic          wr_en_i = 1'b0;
    logic          wr_tgt_i = 1'b0;
    logic [IW-1:0] wr_idx_i = '0;
    logic [63:0]   wr_data_i = '0;
    logic          sts_wr_i = 1'b0;
    logic [NT-1:0] sts_wdata_i = '0;
    logic [31:0]   pin_pulse_o, pin_assert_o, pin_deassert_o, pin_level_o;
    logic [NT-1:0] status_o;
    logic          msi_valid_o, msi_bcast_o;
    logic [7:0]    msi_vector_o, msi_dest_o;
    logic [IW-1:0] msi_src_o;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_steer_top dut (
        .clk(clk), .rst(rst), .fire_i(fire_i), .legacy_i(legacy_i),
        .wr_en_i(wr_en_i), .wr_tgt_i(wr_tgt_i), .wr_idx_i(wr_idx_i),
        .wr_data_i(wr_data_i), .sts_wr_i(sts_wr_i), .sts_wdata_i(sts_wdata_i),
        .pin_pulse_o(pin_pulse_o), .pin_assert_o(pin_assert_o),
        .pin_deassert_o(pin_deassert_o), .pin_level_o(pin_level_o),
        .status_o(status_o), .msi_valid_o(msi_valid_o),
        .msi_vector_o(msi_vector_o), .msi_dest_o(msi_dest_o),
        .msi_bcast_o(msi_bcast_o), .msi_src_o(msi_src_o)
    );

    // config word: bit1 level, bit2 enable, bits 13:9 route, bit14 message enable
    function automatic logic [63:0] cw(bit en, bit lvl, int route, bit msi);
        return (64'(en) << 2) | (64'(lvl) << 1) | (64'(route) << 9) | (64'(msi) << 14);
    endfunction

    typedef struct packed {
        logic [2:0]  t;
        logic        leg;
        logic [63:0] cfg;
        logic [31:0] pulse;
        logic [31:0] asrt;
        logic [7:0]  sts;
        logic        msi;
        logic [7:0]  vec;
    } row_t;

    localparam int NROWS = 12;
    localparam row_t ROWS [NROWS] = '{
        '{3'd0, 1'b0, cw(1,0,10,0), 32'd1 << 10, 32'd0,       8'h00, 1'b0, 8'h00}, // R1
        '{3'd3, 1'b0, cw(1,1,12,0), 32'd0,       32'd1 << 12, 8'h08, 1'b0, 8'h00}, // R2
        '{3'd2, 1'b0, cw(0,0,9,0),  32'd0,       32'd0,       8'h00, 1'b0, 8'h00}, // R3
        '{3'd4, 1'b0, cw(1,0,0,0),  32'd0,       32'd0,       8'h00, 1'b0, 8'h00}, // R4
        '{3'd4, 1'b0, cw(1,0,5,0),  32'd0,       32'd0,       8'h00, 1'b0, 8'h00}, // R4
        '{3'd6, 1'b0, cw(1,0,23,0), 32'd1 << 23, 32'd0,       8'h00, 1'b0, 8'h00}, // R4
        '{3'd6, 1'b0, cw(1,0,24,0), 32'd0,       32'd0,       8'h00, 1'b0, 8'h00}, // R4
        '{3'd1, 1'b0, cw(1,0,10,1), 32'd0,       32'd0,       8'h00, 1'b1, 8'h41}, // R5
        '{3'd0, 1'b1, cw(1,1,12,1), 32'd1 << 2,  32'd0,       8'h00, 1'b0, 8'h00}, // R6
        '{3'd1, 1'b1, cw(1,1,12,0), 32'd1 << 8,  32'd0,       8'h00, 1'b0, 8'h00}, // R6
        '{3'd7, 1'b1, cw(1,1,8,0),  32'd0,       32'd1 << 8,  8'h80, 1'b0, 8'h00}, // R6
        '{3'd2, 1'b0, cw(1,1,0,1),  32'd0,       32'd0,       8'h00, 1'b1, 8'h42}  // R5
    };

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input bit tgt, input int t, input logic [63:0] d);
        wr_en_i = 1'b1; wr_tgt_i = tgt; wr_idx_i = IW'(t); wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic fire(input logic [NT-1:0] m);
        fire_i = m;
        @(negedge clk);
        fire_i = '0;
    endtask

    task automatic sts_clear(input logic [NT-1:0] m);
        sts_wr_i = 1'b1; sts_wdata_i = m;
        @(negedge clk);
        sts_wr_i = 1'b0; sts_wdata_i = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state and zero configuration
        chk("R11", "status", status_o, 0);
        chk("R11", "level", pin_level_o, 0);
        chk("R11", "msi_valid", msi_valid_o, 0);
        fire('1);
        chk("R11", "pulse after fire", pin_pulse_o, 0);
        chk("R11", "assert after fire", pin_assert_o, 0);
        chk("R11", "status after fire", status_o, 0);
        chk("R11", "msi after fire", msi_valid_o, 0);

        // message words: vector 0x40+t, destination t (timer 2 broadcast)
        for (int t = 0; t < NT; t++)
            wr(1'b1, t, ((t == 2 ? 64'hFF : 64'(t)) << 44) | 64'(8'h40 + t));

        // table walk
        for (int i = 0; i < NROWS; i++) begin
            legacy_i = ROWS[i].leg;
            wr(1'b0, int'(ROWS[i].t), ROWS[i].cfg);
            fire(NT'(1) << ROWS[i].t);
            chk($sformatf("row%0d", i), "pulse", pin_pulse_o, ROWS[i].pulse);
            chk($sformatf("row%0d", i), "assert", pin_assert_o, ROWS[i].asrt);
            chk($sformatf("row%0d", i), "status", status_o, ROWS[i].sts);
            chk($sformatf("row%0d", i), "msi_valid", msi_valid_o, ROWS[i].msi);
            if (ROWS[i].msi)
                chk($sformatf("row%0d", i), "vector", msi_vector_o, ROWS[i].vec);
            @(negedge clk);
            sts_clear('1);
            legacy_i = 1'b0;
            wr(1'b0, int'(ROWS[i].t), 64'd0);
        end

        // R1: pulse lasts one cycle
        wr(1'b0, 0, cw(1,0,10,0));
        fire(8'h01);
        chk("R1", "pulse", pin_pulse_o, 32'd1 << 10);
        @(negedge clk);
        chk("R1", "pulse gone", pin_pulse_o, 0);

        // R2 / R3 / R7: level, repeat ignored, clear by writing 1
        wr(1'b0, 3, cw(1,1,12,0));
        fire(8'h08);
        chk("R2", "level held", pin_level_o, 32'd1 << 12);
        fire(8'h08);
        chk("R3", "repeat assert", pin_assert_o, 0);
        chk("R3", "status kept", status_o, 8'h08);
        sts_clear(8'h00);
        chk("R7", "zero write status", status_o, 8'h08);
        chk("R7", "zero write deassert", pin_deassert_o, 0);
        sts_clear(8'h08);
        chk("R7", "status cleared", status_o, 0);
        chk("R7", "deassert", pin_deassert_o, 32'd1 << 12);
        chk("R7", "level dropped", pin_level_o, 0);

        // R8: route change drops stale level one cycle later
        fire(8'h08);
        wr(1'b0, 3, cw(1,1,13,0));
        chk("R8", "status before", status_o, 8'h08);
        @(negedge clk);
        chk("R8", "route change status", status_o, 0);
        chk("R8", "route change deassert", pin_deassert_o, 32'd1 << 12);
        fire(8'h08);
        chk("R8", "new pin assert", pin_assert_o, 32'd1 << 13);
        wr(1'b0, 3, cw(0,1,13,0));
        @(negedge clk);
        chk("R8", "disable status", status_o, 0);
        chk("R8", "disable deassert", pin_deassert_o, 32'd1 << 13);
        wr(1'b0, 3, 64'd0);
        // R8: legacy switch moves timer 0 off its level route
        wr(1'b0, 0, cw(1,1,12,0));
        fire(8'h01);
        chk("R8", "t0 level", status_o, 8'h01);
        legacy_i = 1'b1;
        @(negedge clk);
        chk("R8", "legacy status", status_o, 0);
        chk("R8", "legacy deassert", pin_deassert_o, 32'd1 << 12);
        legacy_i = 1'b0;
        wr(1'b0, 0, 64'd0);

        // R5: broadcast destination
        wr(1'b0, 2, cw(1,0,0,1));
        fire(8'h04);
        chk("R5", "bcast", msi_bcast_o, 1);
        chk("R5", "dest", msi_dest_o, 8'hFF);
        chk("R5", "pulse none", pin_pulse_o, 0);
        @(negedge clk);
        wr(1'b0, 2, 64'd0);

        // R9: ascending order, merge of a repeated fire
        wr(1'b0, 1, cw(1,0,0,1));
        wr(1'b0, 4, cw(1,0,0,1));
        fire_i = 8'h12;
        @(negedge clk);
        fire_i = 8'h10;
        chk("R9", "first src", msi_src_o, 1);
        chk("R9", "first vec", msi_vector_o, 8'h41);
        chk("R9", "first bcast", msi_bcast_o, 0);
        chk("R9", "first dest", msi_dest_o, 8'h01);
        @(negedge clk);
        fire_i = '0;
        chk("R9", "second src", msi_src_o, 4);
        chk("R9", "second vec", msi_vector_o, 8'h44);
        @(negedge clk);
        chk("R9", "merged, queue empty", msi_valid_o, 0);
        wr(1'b0, 1, 64'd0);
        wr(1'b0, 4, 64'd0);

        // R10: same pin from two timers
        wr(1'b0, 0, cw(1,0,10,0));
        wr(1'b0, 6, cw(1,0,10,0));
        fire(8'h41);
        chk("R10", "shared pulse", pin_pulse_o, 32'd1 << 10);
        wr(1'b0, 3, cw(1,1,12,0));
        wr(1'b0, 7, cw(1,1,12,0));
        fire(8'h88);
        chk("R10", "two levels", status_o, 8'h88);
        chk("R10", "shared assert", pin_assert_o, 32'd1 << 12);
        sts_clear(8'h08);
        chk("R10", "one left", status_o, 8'h80);
        chk("R10", "level still held", pin_level_o, 32'd1 << 12);
        chk("R10", "deassert strobe", pin_deassert_o, 32'd1 << 12);
        sts_clear('1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule